// File: doc/BRIEF.md
# Multi-Format Pixel Unpacker with Palette

This block sits between a memory read path and a display pipeline. It accepts 32-bit words from system memory on a valid/ready stream and emits 16-bit RGB565 pixels on a second valid/ready stream. A control register selects how the bits of each word are read. The choices are grayscale at 1, 2, 4 or 6 bits per pixel, palettized color at 4 or 8 bits per pixel, or direct color at 15 or 16 bits per pixel. A second control bit reverses the byte order of each incoming word before any pixel is taken from it.

Pixels are taken from a bit stream, most significant bit first. Packed sub-byte pixels therefore come out in order from the top of each byte. In the 6-bit grayscale mode a pixel may span two words. The bits left over at the end of a word are kept in a residual register, so no input bit is lost. Indexed pixels address a 256-entry palette, which software writes through the same register port. Each palette word is 24 bits wide, and only its top 5/6/5 bits per channel are kept.

The block is built around two small state machines. The extraction machine has the states ALIGNED (no residual bits held) and CARRY (residual bits held from the previous word). It moves from ALIGNED to CARRY when a word ends with unused bits. It moves from CARRY to ALIGNED when a word ends exactly on a pixel boundary, or when the control register is written. The output machine has the states EMPTY and FULL. It moves from EMPTY to FULL on a pixel take. It moves from FULL to EMPTY when the pixel is accepted and no new take happens. It stays in FULL while the pixel is held, or when one pixel replaces another.

Top module: `pix_unpack`

## Requirements
- R1: After reset, out_valid and in_ready are low, the mode is direct 16-bit color (code 7) and byte reversal is off.
- R2: Once out_valid is high, out_valid and out_pixel stay unchanged until a cycle in which out_ready is high.
- R3: A pixel taken at a clock edge appears on the output after that edge, one cycle of latency for every mode. in_ready is high only in the cycle in which the last whole pixel of the current word is taken. With out_ready held high, a word of k pixels therefore sees in_ready in its k-th cycle.
- R4: Grayscale codes 0, 1 and 2 (1, 2 and 4 bits per pixel) take pixels from the stream starting at its MSB. Each value is widened to 8 bits by repeating its own bits from the top, giving g8. The output is {g8[7:3], g8[7:2], g8[7:3]}.
- R5: Grayscale code 3 (6 bits per pixel) carries leftover bits from one word into the next. Three consecutive words give 16 pixels in stream order. The value is widened to {v[5:0], v[5:4]} and then mapped to RGB565 as in R4.
- R6: Direct code 7 gives two pixels per word, bits [31:16] first. Direct code 6 reads R from [14:10], G from [9:5] and B from [4:0], ignores bit 15, and outputs {R, G, G[4], B}.
- R7: Indexed codes 4 and 5 (4 and 8 bits per pixel) use the pixel value as a palette index. A palette word holds R in [23:16], G in [15:8] and B in [7:0]. The output is {R[7:3], G[7:2], B[7:3]}, and the low channel bits have no effect.
- R8: When byte reversal is set, the stream is read from {d[7:0], d[15:8], d[23:16], d[31:24]} of the input word d.
- R9: A control write uses reg_we=1 and reg_pal=0, with the mode in reg_wdata[2:0] and byte reversal in reg_wdata[3]. No word is consumed in that cycle. The write discards any residual bits and restarts extraction at the start of the held word.
- R10: A palette write uses reg_we=1, reg_pal=1, index reg_addr and value reg_wdata. If it hits the index being looked up at the same edge, the lookup returns the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Word from memory |
| in_ready | output | 1 | Word consumed at this edge |
| reg_we | input | 1 | Register write strobe |
| reg_pal | input | 1 | 1 = palette entry, 0 = control register |
| reg_addr | input | 8 | Palette index |
| reg_wdata | input | 24 | Palette word or control value |
| out_valid | output | 1 | Pixel valid |
| out_pixel | output | 16 | RGB565 pixel |
| out_ready | input | 1 | Downstream accepts pixel |

## Verification
A palette write and an indexed lookup can both land on the same clock edge at the same index. The bench provokes this by raising a palette write to the index of the first byte of an 8-bit indexed word, in the same cycle that word is first offered with the output free. The scoreboard expects the new color for that pixel and the new color for later pixels too. A second overlap is a control write against a pending word. Here the bench discards the residual 6-bit stream and checks that the next words line up from a fresh start.

// File: rtl/pu_pkg.sv
`timescale 1ns/1ps
package pu_pkg;

    typedef enum logic [2:0] {
        PM_GRAY1 = 3'd0,
        PM_GRAY2 = 3'd1,
        PM_GRAY4 = 3'd2,
        PM_GRAY6 = 3'd3,
        PM_IDX4  = 3'd4,
        PM_IDX8  = 3'd5,
        PM_RGB15 = 3'd6,
        PM_RGB16 = 3'd7
    } pix_mode_e;

    function automatic logic [4:0] mode_bpp(input pix_mode_e m);
        logic [4:0] b;
        unique case (m)
            PM_GRAY1: b = 5'd1;
            PM_GRAY2: b = 5'd2;
            PM_GRAY4: b = 5'd4;
            PM_GRAY6: b = 5'd6;
            PM_IDX4:  b = 5'd4;
            PM_IDX8:  b = 5'd8;
            default:  b = 5'd16;
        endcase
        return b;
    endfunction

    function automatic logic mode_indexed(input pix_mode_e m);
        return (m == PM_IDX4) || (m == PM_IDX8);
    endfunction

endpackage

// File: rtl/pu_extract.sv
`timescale 1ns/1ps
module pu_extract #(
    parameter int WORD_W = 32,
    parameter int PIX_W  = 16,
    parameter int RES_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_i,
    input  logic [4:0]        bpp_i,
    input  logic              take_i,
    input  logic              flush_i,
    output logic [PIX_W-1:0]  raw_o,
    output logic              last_o
);
    localparam int CAT_W = WORD_W + RES_W;
    localparam int CNT_W = $clog2(CAT_W + 1);
    localparam int RCW   = $clog2(RES_W + 1);

    typedef enum logic {EX_ALIGNED, EX_CARRY} ex_state_e;

    ex_state_e          st_q, st_d;
    logic [RES_W-1:0]   resid_q, resid_d;
    logic [RCW-1:0]     rcnt_q, rcnt_d;
    logic [CNT_W-1:0]   pos_q, pos_d;

    logic [CAT_W-1:0]   cat, win;
    logic [CNT_W-1:0]   avail, shamt, pos_nx, rem, bpp_w;
    logic [PIX_W-1:0]   mask;

    assign cat   = {resid_q, word_i};
    assign bpp_w = CNT_W'(bpp_i);

    // window size depends on whether residual bits are held
    always_comb begin
        unique case (st_q)
            EX_ALIGNED: avail = CNT_W'(WORD_W);
            EX_CARRY:   avail = CNT_W'(WORD_W) + CNT_W'(rcnt_q);
            default:    avail = CNT_W'(WORD_W);
        endcase
    end

    // outputs: pixel bits and end-of-word flag
    always_comb begin
        shamt  = avail - pos_q - bpp_w;
        win    = cat >> shamt;
        mask   = PIX_W'((32'd1 << bpp_i) - 32'd1);
        raw_o  = win[PIX_W-1:0] & mask;
        pos_nx = pos_q + bpp_w;
        rem    = avail - pos_nx;
        last_o = (rem < bpp_w);
    end

    // next state
    always_comb begin
        st_d    = st_q;
        pos_d   = pos_q;
        rcnt_d  = rcnt_q;
        resid_d = resid_q;
        if (flush_i) begin
            st_d   = EX_ALIGNED;
            pos_d  = '0;
            rcnt_d = '0;
        end else if (take_i) begin
            if (last_o) begin
                pos_d   = '0;
                rcnt_d  = RCW'(rem);
                resid_d = cat[RES_W-1:0];
                st_d    = (rem != '0) ? EX_CARRY : EX_ALIGNED;
            end else begin
                pos_d = pos_nx;
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= EX_ALIGNED;
            pos_q   <= '0;
            rcnt_q  <= '0;
            resid_q <= '0;
        end else begin
            st_q    <= st_d;
            pos_q   <= pos_d;
            rcnt_q  <= rcnt_d;
            resid_q <= resid_d;
        end
    end
endmodule

// File: rtl/pu_palette.sv
`timescale 1ns/1ps
module pu_palette #(
    parameter int AW = 8,
    parameter int DW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [15:0]   rdata
);
    localparam int DEPTH = 1 << AW;
    localparam int CH_W  = DW / 3;

    logic [15:0] mem [DEPTH];
    logic [15:0] packed_w;

    assign packed_w = {wdata[DW-1 -: 5], wdata[2*CH_W-1 -: 6], wdata[CH_W-1 -: 5]};

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= packed_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= (we && (waddr == raddr)) ? packed_w : mem[raddr];
    end
endmodule

// File: rtl/pu_expand.sv
`timescale 1ns/1ps
module pu_expand
    import pu_pkg::*;
#(
    parameter int PIX_W = 16
) (
    input  pix_mode_e        mode_i,
    input  logic [PIX_W-1:0] raw_i,
    output logic [15:0]      pix_o
);
    logic [7:0] g8;

    always_comb begin
        unique case (mode_i)
            PM_GRAY1: g8 = {8{raw_i[0]}};
            PM_GRAY2: g8 = {4{raw_i[1:0]}};
            PM_GRAY4: g8 = {2{raw_i[3:0]}};
            PM_GRAY6: g8 = {raw_i[5:0], raw_i[5:4]};
            default:  g8 = 8'h00;
        endcase
        unique case (mode_i)
            PM_RGB15: pix_o = {raw_i[14:10], raw_i[9:5], raw_i[9], raw_i[4:0]};
            PM_RGB16: pix_o = raw_i[15:0];
            PM_IDX4,
            PM_IDX8:  pix_o = 16'h0000;
            default:  pix_o = {g8[7:3], g8[7:2], g8[7:3]};
        endcase
    end
endmodule

// File: rtl/pix_unpack.sv
`timescale 1ns/1ps
module pix_unpack
    import pu_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int PIX_W  = 16,
    parameter int PAL_AW = 8,
    parameter int PAL_DW = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    input  logic              reg_we,
    input  logic              reg_pal,
    input  logic [PAL_AW-1:0] reg_addr,
    input  logic [PAL_DW-1:0] reg_wdata,
    output logic              out_valid,
    output logic [PIX_W-1:0]  out_pixel,
    input  logic              out_ready
);
    localparam int NBYTES = WORD_W / 8;

    typedef enum logic {OS_EMPTY, OS_FULL} out_state_e;

    out_state_e        os_q, os_d;
    pix_mode_e         mode_q;
    logic              swap_q;
    logic              cfg_wr, take, last;
    logic [WORD_W-1:0] word_sw, word_use;
    logic [PIX_W-1:0]  raw;
    logic [15:0]       conv, conv_q, pal_q;
    logic              idx_q;

    genvar gi;
    generate
        for (gi = 0; gi < NBYTES; gi++) begin : g_swap
            assign word_sw[8*gi +: 8] = in_data[8*(NBYTES-1-gi) +: 8];
        end
    endgenerate
    assign word_use = swap_q ? word_sw : in_data;

    assign cfg_wr   = reg_we && !reg_pal;
    assign take     = in_valid && !cfg_wr && ((os_q == OS_EMPTY) || out_ready);
    assign in_ready = take && last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= PM_RGB16;
            swap_q <= 1'b0;
        end else if (cfg_wr) begin
            mode_q <= pix_mode_e'(reg_wdata[2:0]);
            swap_q <= reg_wdata[3];
        end
    end

    pu_extract #(.WORD_W(WORD_W), .PIX_W(PIX_W), .RES_W(5)) u_extract (
        .clk     (clk),
        .rst_n   (rst_n),
        .word_i  (word_use),
        .bpp_i   (mode_bpp(mode_q)),
        .take_i  (take),
        .flush_i (cfg_wr),
        .raw_o   (raw),
        .last_o  (last)
    );

    pu_expand #(.PIX_W(PIX_W)) u_expand (
        .mode_i (mode_q),
        .raw_i  (raw),
        .pix_o  (conv)
    );

    pu_palette #(.AW(PAL_AW), .DW(PAL_DW)) u_palette (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we && reg_pal),
        .waddr (reg_addr),
        .wdata (reg_wdata),
        .re    (take && mode_indexed(mode_q)),
        .raddr (raw[PAL_AW-1:0]),
        .rdata (pal_q)
    );

    // output stage: next state
    always_comb begin
        os_d = os_q;
        unique case (os_q)
            OS_EMPTY: if (take) os_d = OS_FULL;
            OS_FULL:  if (!take && out_ready) os_d = OS_EMPTY;
            default:  os_d = OS_EMPTY;
        endcase
    end

    // output stage: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) os_q <= OS_EMPTY;
        else        os_q <= os_d;
    end

    // output stage: data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            conv_q <= '0;
            idx_q  <= 1'b0;
        end else if (take) begin
            conv_q <= conv;
            idx_q  <= mode_indexed(mode_q);
        end
    end

    assign out_valid = (os_q == OS_FULL);
    assign out_pixel = PIX_W'(idx_q ? pal_q : conv_q);
endmodule

// File: rtl/pix_unpack_chk.sv
`timescale 1ns/1ps
module pix_unpack_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] in_data,
    input logic        in_ready,
    input logic        reg_we,
    input logic        reg_pal,
    input logic        out_valid,
    input logic [15:0] out_pixel,
    input logic        out_ready,
    input logic [2:0]  mode,
    input logic        swap
);
    a_r2_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_pixel)));

    a_r3_word_gives_pixel: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> out_valid);

    a_r3_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> in_valid);

    a_r9_cfg_blocks_take: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !reg_pal) |-> !in_ready);

    a_r6_direct16_tail: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && mode == 3'd7 && !swap) |=> (out_pixel == $past(in_data[15:0])));

    a_r4_gray1_tail: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && mode == 3'd0 && !swap) |=> (out_pixel == {16{$past(in_data[0])}}));
endmodule

bind pix_unpack pix_unpack_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .reg_we    (reg_we),
    .reg_pal   (reg_pal),
    .out_valid (out_valid),
    .out_pixel (out_pixel),
    .out_ready (out_ready),
    .mode      (mode_q),
    .swap      (swap_q)
);

// File: tb/pix_unpack_tb.sv
`timescale 1ns/1ps
module pix_unpack_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready;
    logic        reg_we = 1'b0;
    logic        reg_pal = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [23:0] reg_wdata = '0;
    logic        out_valid;
    logic [15:0] out_pixel;
    logic        out_ready = 1'b1;

    int n_cmp = 0;
    int n_bad = 0;
    int rdy_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic [15:0] exp_q[$];
    string       tag_q[$];
    bit          bq[$];
    logic [23:0] pal_m [256];
    int          cur_mode = 7;
    bit          cur_swap = 1'b0;
    string       tag_ovr = "";
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pix_unpack u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .reg_we(reg_we), .reg_pal(reg_pal),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .out_valid(out_valid),
        .out_pixel(out_pixel), .out_ready(out_ready)
    );

    function automatic int bpp_of(input int m);
        case (m)
            0: return 1;  1: return 2;  2: return 4;  3: return 6;
            4: return 4;  5: return 8;  default: return 16;
        endcase
    endfunction

    function automatic logic [15:0] pack565(input logic [23:0] w);
        return {w[23:19], w[15:10], w[7:3]};
    endfunction

    function automatic logic [15:0] expect_pix(input int m, input logic [15:0] v);
        logic [7:0] g8;
        int b;
        b = bpp_of(m);
        if (m <= 3) begin
            for (int i = 0; i < 8; i++) g8[7-i] = v[b-1-(i % b)];
            return {g8[7:3], g8[7:2], g8[7:3]};
        end
        if (m == 4 || m == 5) return pack565(pal_m[v[7:0]]);
        if (m == 6) return {v[14:10], v[9:5], v[9], v[4:0]};
        return v;
    endfunction

    function automatic string tag_of(input int m);
        if (tag_ovr != "") return tag_ovr;
        if (cur_swap) return "R8";
        if (m <= 2) return "R4";
        if (m == 3) return "R5";
        if (m == 4 || m == 5) return "R7";
        return "R6";
    endfunction

    task automatic check(input string req, input bit ok, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // model: push bits of one word, pop whole pixels into the scoreboard
    task automatic model_word(input logic [31:0] w, output int k);
        logic [31:0] s;
        logic [15:0] v;
        int b;
        s = cur_swap ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
        for (int i = 31; i >= 0; i--) bq.push_back(s[i]);
        b = bpp_of(cur_mode);
        k = 0;
        while (bq.size() >= b) begin
            v = '0;
            for (int j = 0; j < b; j++) v = {v[14:0], bq.pop_front()};
            exp_q.push_back(expect_pix(cur_mode, v));
            tag_q.push_back(tag_of(cur_mode));
            k++;
        end
    endtask

    // driver: offer one word, optionally with a palette write in its first cycle
    task automatic send_word(input logic [31:0] w, input bit pw, input logic [7:0] pa, input logic [23:0] pd);
        int k;
        int waits;
        @(negedge clk);
        if (pw) begin
            pal_m[pa] = pd;
            reg_we = 1'b1; reg_pal = 1'b1; reg_addr = pa; reg_wdata = pd;
        end
        model_word(w, k);
        in_valid = 1'b1;
        in_data  = w;
        waits = 0;
        forever begin
            #2;
            waits++;
            if (in_ready) break;
            @(negedge clk);
            reg_we = 1'b0;
        end
        if (rdy_mode == 0)
            check("R3 word-consume cycle", waits == k, waits, k);
        @(negedge clk);
        reg_we   = 1'b0;
        in_valid = 1'b0;
    endtask

    task automatic set_mode(input int m, input bit sw);
        @(negedge clk);
        reg_we = 1'b1; reg_pal = 1'b0; reg_wdata = {20'h0, sw, 3'(m)};
        @(negedge clk);
        reg_we = 1'b0;
        bq.delete();
        cur_mode = m;
        cur_swap = sw;
    endtask

    task automatic pal_write(input logic [7:0] a, input logic [23:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_pal = 1'b1; reg_addr = a; reg_wdata = d;
        pal_m[a] = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic drain();
        rdy_mode = 0;
        while (exp_q.size() > 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // monitor / scoreboard
    bit          hold_prev = 1'b0;
    logic [15:0] prev_pix = '0;
    initial begin
        forever begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            out_ready = (rdy_mode == 0) ? 1'b1 : (lfsr[0] | lfsr[5]);
            #1;
            if (rst_n) begin
                if (hold_prev)
                    check("R2 hold", out_valid && out_pixel == prev_pix, {out_valid, out_pixel}, {1'b1, prev_pix});
                if (out_valid && out_ready) begin
                    if (exp_q.size() == 0)
                        check("R3 unexpected pixel", 1'b0, out_pixel, 0);
                    else begin
                        logic [15:0] e;
                        string t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        check(t, out_pixel == e, out_pixel, e);
                    end
                end
                hold_prev = out_valid && !out_ready;
                prev_pix  = out_pixel;
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1 out_valid after reset", out_valid == 1'b0, out_valid, 0);
        check("R1 in_ready after reset", in_ready == 1'b0, in_ready, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: default mode is direct 16-bit, no reversal
        send_word(32'h1234_5678, 0, 0, 0);
        send_word(32'hFFFF_0000, 0, 0, 0);
        drain();

        // R8 byte reversal in 16-bit mode
        set_mode(7, 1);
        send_word(32'h1122_3344, 0, 0, 0);
        send_word(32'hA1B2_C3D4, 0, 0, 0);
        drain();

        // R6 15-bit direct
        set_mode(6, 0);
        send_word(32'h8000_7FFF, 0, 0, 0);
        send_word(32'h7C1F_83E0, 0, 0, 0);
        drain();

        // R4 grayscale 1/2/4
        set_mode(0, 0);
        send_word(32'hA5F0_0F81, 0, 0, 0);
        set_mode(1, 0);
        send_word(32'h1BE4_00FF, 0, 0, 0);
        set_mode(2, 0);
        send_word(32'h0123_89EF, 0, 0, 0);
        drain();

        // R5 6-bit grayscale, words straddle
        set_mode(3, 0);
        send_word(32'h0420_C4F1, 0, 0, 0);
        send_word(32'hFEDC_BA98, 0, 0, 0);
        send_word(32'h1357_9BDF, 0, 0, 0);
        drain();

        // R9 control write discards residual bits
        send_word(32'hDEAD_BEEF, 0, 0, 0);
        drain();
        tag_ovr = "R9";
        set_mode(3, 0);
        send_word(32'h0F0F_0F0F, 0, 0, 0);
        send_word(32'hC3C3_3C3C, 0, 0, 0);
        tag_ovr = "";
        drain();

        // R7 indexed
        for (int i = 0; i < 16; i++) pal_write(8'(i), 24'(i * 24'h10_2F_37 + 24'h07_03_05));
        pal_write(8'hA7, 24'hF8_FC_F8);
        pal_write(8'h3C, 24'h12_34_56);
        pal_write(8'hFF, 24'h07_03_07);
        set_mode(4, 0);
        send_word(32'h0123_4567, 0, 0, 0);
        send_word(32'h89AB_CDEF, 0, 0, 0);
        set_mode(5, 0);
        send_word(32'hA73C_FF00, 0, 0, 0);
        drain();

        // R2 with stalls, several modes
        rdy_mode = 1;
        set_mode(5, 0);
        send_word(32'h3CA7_01FF, 0, 0, 0);
        set_mode(3, 1);
        send_word(32'h1234_5678, 0, 0, 0);
        send_word(32'h9ABC_DEF0, 0, 0, 0);
        send_word(32'h5555_AAAA, 0, 0, 0);
        set_mode(7, 0);
        send_word(32'hCAFE_F00D, 0, 0, 0);
        set_mode(1, 1);
        send_word(32'h0F1E_2D3C, 0, 0, 0);
        drain();

        // R10 palette write colliding with lookup
        set_mode(5, 0);
        tag_ovr = "R10";
        send_word(32'h3C01_0203, 1, 8'h3C, 24'hE0_1C_A8);
        send_word(32'h3C3C_0000, 0, 0, 0);
        tag_ovr = "";
        drain();

        done = 1'b1;
        summary();
    end
endmodule